// File: doc/BRIEF.md
# Queue Doorbell Decoder and Tracker

This block tracks pointer state for a set of paired submission and completion queues and turns host doorbell writes into queue events. Each submission queue holds a head, a tail, a size, a presence flag and the completion queue it reports to. Each completion queue holds a head, a tail, a size, a presence flag, an interrupt enable and a phase tag.

Doorbell writes share one address window. A write to a submission-tail slot moves that queue's tail and raises a fetch request for it. A write to a completion-head slot moves that queue's head. It wakes the stalled producers if the queue had been full, and it raises an interrupt while entries are still outstanding.

A post port claims the next completion slot and returns the status word with the phase tag in bit 0. A pop port consumes submission entries for the command fetcher. A configure port creates and removes queues.

Top module: `qdb_tracker`

## Requirements
- R1: A doorbell write is decoded only when the address is at or above 0x1000, its two low bits are zero, and the slot index (address − 0x1000) >> 3 is below NUM_Q. Bit 2 of (address − 0x1000) selects the kind: 0 is a submission tail and 1 is a completion head. Every other write has no effect.
- R2: An accepted submission-tail write stores the new tail. It drives fetch_req_o bit qid high for exactly the one cycle after the write edge.
- R3: A doorbell that names an absent queue, or whose value is greater than or equal to that queue's size, changes no pointer and raises no request.
- R4: An accepted completion-head write stores the new head. If the queue's interrupt enable is set and its tail differs from the new head, irq_o bit qid pulses for the one cycle after the write edge.
- R5: If the completion queue was full before an accepted head write, retry_req_o bit qid pulses in that same cycle. fetch_req_o also pulses for every present submission queue bound to that completion queue. A queue counts as full when (tail+1) mod size equals head.
- R6: A post is accepted (post_ok_o) when the named completion queue is present and not full. post_word_o is {status, phase}, post_slot_o is the completion tail, and post_sq_head_o is the named submission queue's head.
- R7: A post to an absent or full completion queue raises post_busy_o and leaves all pointers and the phase unchanged.
- R8: An accepted post advances the completion tail. When the tail wraps from size−1 to 0, the phase tag inverts.
- R9: A pop is accepted (pop_ok_o) only when the submission queue is present and head ≠ tail. It then returns the head on pop_slot_o and advances the head with wrap at size.
- R10: A configure operation takes cfg_op_i 0 to create a submission queue, 1 to create a completion queue, 2 to remove a submission queue and 3 to remove a completion queue. Creation sets size to cfg_size_i+1 and zeroes both pointers. For a completion queue it also sets the phase to 1.
- R11: After reset no queue is present and fetch_req_o, retry_req_o and irq_o are all zero.
- R12: Only bits 15:0 of db_data_i take part in the range check and the pointer update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Configure strobe |
| cfg_op_i | input | 2 | 0 create SQ, 1 create CQ, 2 remove SQ, 3 remove CQ |
| cfg_qid_i | input | QID_W | Queue id to configure |
| cfg_size_i | input | PTR_W | Size field (size = field + 1) |
| cfg_cqid_i | input | QID_W | Completion queue bound to a new SQ |
| cfg_ien_i | input | 1 | Interrupt enable for a new CQ |
| db_valid_i | input | 1 | Doorbell write strobe |
| db_addr_i | input | ADDR_W | Doorbell byte address |
| db_data_i | input | 32 | Doorbell write data |
| post_valid_i | input | 1 | Completion post request |
| post_cqid_i | input | QID_W | Target completion queue |
| post_sqid_i | input | QID_W | Originating submission queue |
| post_status_i | input | ST_W | Completion status code |
| post_ok_o | output | 1 | Post accepted |
| post_busy_o | output | 1 | Post refused |
| post_word_o | output | ST_W+1 | Status word {status, phase} |
| post_slot_o | output | PTR_W | Completion slot written |
| post_sq_head_o | output | PTR_W | Current head of post_sqid_i |
| pop_valid_i | input | 1 | Submission consume request |
| pop_sqid_i | input | QID_W | Submission queue to consume from |
| pop_ok_o | output | 1 | Pop accepted |
| pop_slot_o | output | PTR_W | Submission slot consumed |
| fetch_req_o | output | NUM_Q | Per-SQ fetch request pulses |
| retry_req_o | output | NUM_Q | Per-CQ post retry pulses |
| irq_o | output | NUM_Q | Per-CQ interrupt pulses |

## Verification
The bench builds the block with NUM_Q=4 and PTR_W=3, so that queue sizes run from 1 to 8. With sizes that small, a few dozen posts wrap every tail several times and exercise both phase values. Every full condition, including the always-full size-1 queue, can be reached in a handful of operations. The bench sweeps every byte address from just below the window to past its end, which covers misaligned addresses, out-of-range slots and oversize values in one pass. A reference model in the bench tracks all pointers and predicts each pulse, slot and status word.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  typedef enum logic [1:0] {
    CFG_MK_SQ = 2'd0,
    CFG_MK_CQ = 2'd1,
    CFG_RM_SQ = 2'd2,
    CFG_RM_CQ = 2'd3
  } qdb_cfg_e;

  localparam int unsigned DB_VAL_W = 16;
endpackage

// File: rtl/qdb_decode.sv
module qdb_decode #(
  parameter int unsigned NUM_Q   = 64,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DB_BASE = 'h1000,
  localparam int unsigned QID_W  = $clog2(NUM_Q)
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       data_i,
  output logic              sq_wr_o,
  output logic              cq_wr_o,
  output logic [QID_W-1:0]  qid_o,
  output logic [15:0]       val_o
);
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-4:0] slot;
  logic              hit;
  logic              unused_hi;

  assign off       = addr_i - ADDR_W'(DB_BASE);
  assign slot      = off[ADDR_W-1:3];
  assign hit       = valid_i && (addr_i >= ADDR_W'(DB_BASE)) && (off[1:0] == 2'b00)
                     && (slot < (ADDR_W-3)'(NUM_Q));
  assign sq_wr_o   = hit && !off[2];
  assign cq_wr_o   = hit && off[2];
  assign qid_o     = slot[QID_W-1:0];
  assign val_o     = data_i[15:0];
  assign unused_hi = ^data_i[31:16];
endmodule

// File: rtl/qdb_sq_bank.sv
module qdb_sq_bank
  import qdb_pkg::*;
#(
  parameter int unsigned NUM_Q = 64,
  parameter int unsigned PTR_W = 16,
  localparam int unsigned QID_W = $clog2(NUM_Q),
  localparam int unsigned SZ_W  = PTR_W + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_valid_i,
  input  qdb_cfg_e                    cfg_op_i,
  input  logic [QID_W-1:0]            cfg_qid_i,
  input  logic [PTR_W-1:0]            cfg_size_i,
  input  logic [QID_W-1:0]            cfg_cqid_i,
  input  logic                        tl_wr_i,
  input  logic [QID_W-1:0]            tl_qid_i,
  input  logic [15:0]                 tl_val_i,
  output logic                        tl_acc_o,
  input  logic                        pop_valid_i,
  input  logic [QID_W-1:0]            pop_sqid_i,
  output logic                        pop_ok_o,
  output logic [PTR_W-1:0]            pop_slot_o,
  input  logic [QID_W-1:0]            hd_sel_i,
  output logic [PTR_W-1:0]            hd_o,
  output logic [NUM_Q-1:0]            vld_o,
  output logic [NUM_Q-1:0][QID_W-1:0] cq_o
);
  logic [NUM_Q-1:0]            vld_q;
  logic [NUM_Q-1:0][SZ_W-1:0]  size_q;
  logic [NUM_Q-1:0][PTR_W-1:0] head_q;
  logic [NUM_Q-1:0][PTR_W-1:0] tail_q;
  logic [NUM_Q-1:0][QID_W-1:0] cq_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                            input logic [SZ_W-1:0] sz);
    return (SZ_W'(p) + 1'b1 == sz) ? '0 : p + 1'b1;
  endfunction

  assign tl_acc_o   = tl_wr_i && vld_q[tl_qid_i] &&
                      (32'(tl_val_i) < 32'(size_q[tl_qid_i]));
  assign pop_ok_o   = pop_valid_i && vld_q[pop_sqid_i] &&
                      (head_q[pop_sqid_i] != tail_q[pop_sqid_i]);
  assign pop_slot_o = head_q[pop_sqid_i];
  assign hd_o       = head_q[hd_sel_i];
  assign vld_o      = vld_q;
  assign cq_o       = cq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      size_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      cq_q   <= '0;
    end else begin
      if (tl_acc_o) tail_q[tl_qid_i] <= tl_val_i[PTR_W-1:0];
      if (pop_ok_o) head_q[pop_sqid_i] <= bump(head_q[pop_sqid_i], size_q[pop_sqid_i]);
      // configure wins over same-cycle pointer traffic
      if (cfg_valid_i) begin
        unique case (cfg_op_i)
          CFG_MK_SQ: begin
            vld_q[cfg_qid_i]  <= 1'b1;
            size_q[cfg_qid_i] <= SZ_W'(cfg_size_i) + 1'b1;
            head_q[cfg_qid_i] <= '0;
            tail_q[cfg_qid_i] <= '0;
            cq_q[cfg_qid_i]   <= cfg_cqid_i;
          end
          CFG_RM_SQ: vld_q[cfg_qid_i] <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/qdb_cq_bank.sv
module qdb_cq_bank
  import qdb_pkg::*;
#(
  parameter int unsigned NUM_Q = 64,
  parameter int unsigned PTR_W = 16,
  parameter int unsigned ST_W  = 15,
  localparam int unsigned QID_W = $clog2(NUM_Q),
  localparam int unsigned SZ_W  = PTR_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_valid_i,
  input  qdb_cfg_e           cfg_op_i,
  input  logic [QID_W-1:0]   cfg_qid_i,
  input  logic [PTR_W-1:0]   cfg_size_i,
  input  logic               cfg_ien_i,
  input  logic               hd_wr_i,
  input  logic [QID_W-1:0]   hd_qid_i,
  input  logic [15:0]        hd_val_i,
  output logic               wake_o,
  input  logic               post_valid_i,
  input  logic [QID_W-1:0]   post_cqid_i,
  input  logic [ST_W-1:0]    post_status_i,
  output logic               post_ok_o,
  output logic               post_busy_o,
  output logic [ST_W:0]      post_word_o,
  output logic [PTR_W-1:0]   post_slot_o,
  output logic [NUM_Q-1:0]   retry_o,
  output logic [NUM_Q-1:0]   irq_o
);
  logic [NUM_Q-1:0]            vld_q;
  logic [NUM_Q-1:0]            ien_q;
  logic [NUM_Q-1:0]            phase_q;
  logic [NUM_Q-1:0][SZ_W-1:0]  size_q;
  logic [NUM_Q-1:0][PTR_W-1:0] head_q;
  logic [NUM_Q-1:0][PTR_W-1:0] tail_q;
  logic [NUM_Q-1:0]            retry_q;
  logic [NUM_Q-1:0]            irq_q;
  logic                        hd_acc;
  logic                        was_full;
  logic                        post_full;
  logic [PTR_W-1:0]            post_next;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                            input logic [SZ_W-1:0] sz);
    return (SZ_W'(p) + 1'b1 == sz) ? '0 : p + 1'b1;
  endfunction

  assign hd_acc    = hd_wr_i && vld_q[hd_qid_i] &&
                     (32'(hd_val_i) < 32'(size_q[hd_qid_i]));
  assign was_full  = bump(tail_q[hd_qid_i], size_q[hd_qid_i]) == head_q[hd_qid_i];
  assign wake_o    = hd_acc && was_full;

  assign post_full   = bump(tail_q[post_cqid_i], size_q[post_cqid_i]) == head_q[post_cqid_i];
  assign post_ok_o   = post_valid_i && vld_q[post_cqid_i] && !post_full;
  assign post_busy_o = post_valid_i && !post_ok_o;
  assign post_word_o = {post_status_i, phase_q[post_cqid_i]};
  assign post_slot_o = tail_q[post_cqid_i];
  assign post_next   = bump(tail_q[post_cqid_i], size_q[post_cqid_i]);

  assign retry_o = retry_q;
  assign irq_o   = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      ien_q   <= '0;
      phase_q <= '1;
      size_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      retry_q <= '0;
      irq_q   <= '0;
    end else begin
      retry_q <= wake_o ? (NUM_Q'(1) << hd_qid_i) : '0;
      irq_q   <= (hd_acc && ien_q[hd_qid_i] && (tail_q[hd_qid_i] != hd_val_i[PTR_W-1:0]))
                 ? (NUM_Q'(1) << hd_qid_i) : '0;
      if (hd_acc) head_q[hd_qid_i] <= hd_val_i[PTR_W-1:0];
      if (post_ok_o) begin
        tail_q[post_cqid_i] <= post_next;
        if (post_next == '0) phase_q[post_cqid_i] <= ~phase_q[post_cqid_i];
      end
      if (cfg_valid_i) begin
        unique case (cfg_op_i)
          CFG_MK_CQ: begin
            vld_q[cfg_qid_i]   <= 1'b1;
            ien_q[cfg_qid_i]   <= cfg_ien_i;
            phase_q[cfg_qid_i] <= 1'b1;
            size_q[cfg_qid_i]  <= SZ_W'(cfg_size_i) + 1'b1;
            head_q[cfg_qid_i]  <= '0;
            tail_q[cfg_qid_i]  <= '0;
          end
          CFG_RM_CQ: vld_q[cfg_qid_i] <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/qdb_tracker.sv
module qdb_tracker
  import qdb_pkg::*;
#(
  parameter int unsigned NUM_Q   = 64,
  parameter int unsigned PTR_W   = 16,
  parameter int unsigned ST_W    = 15,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DB_BASE = 'h1000,
  localparam int unsigned QID_W  = $clog2(NUM_Q)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [1:0]        cfg_op_i,
  input  logic [QID_W-1:0]  cfg_qid_i,
  input  logic [PTR_W-1:0]  cfg_size_i,
  input  logic [QID_W-1:0]  cfg_cqid_i,
  input  logic              cfg_ien_i,
  input  logic              db_valid_i,
  input  logic [ADDR_W-1:0] db_addr_i,
  input  logic [31:0]       db_data_i,
  input  logic              post_valid_i,
  input  logic [QID_W-1:0]  post_cqid_i,
  input  logic [QID_W-1:0]  post_sqid_i,
  input  logic [ST_W-1:0]   post_status_i,
  output logic              post_ok_o,
  output logic              post_busy_o,
  output logic [ST_W:0]     post_word_o,
  output logic [PTR_W-1:0]  post_slot_o,
  output logic [PTR_W-1:0]  post_sq_head_o,
  input  logic              pop_valid_i,
  input  logic [QID_W-1:0]  pop_sqid_i,
  output logic              pop_ok_o,
  output logic [PTR_W-1:0]  pop_slot_o,
  output logic [NUM_Q-1:0]  fetch_req_o,
  output logic [NUM_Q-1:0]  retry_req_o,
  output logic [NUM_Q-1:0]  irq_o
);
  qdb_cfg_e                    cfg_op;
  logic                        sq_wr;
  logic                        cq_wr;
  logic [QID_W-1:0]            db_qid;
  logic [15:0]                 db_val;
  logic                        tl_acc;
  logic                        wake;
  logic [NUM_Q-1:0]            sq_vld;
  logic [NUM_Q-1:0][QID_W-1:0] sq_cq;
  logic [NUM_Q-1:0]            bound;
  logic [NUM_Q-1:0]            fetch_d;
  logic [NUM_Q-1:0]            fetch_q;

  assign cfg_op = qdb_cfg_e'(cfg_op_i);

  qdb_decode #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .DB_BASE(DB_BASE)) u_dec (
    .valid_i (db_valid_i),
    .addr_i  (db_addr_i),
    .data_i  (db_data_i),
    .sq_wr_o (sq_wr),
    .cq_wr_o (cq_wr),
    .qid_o   (db_qid),
    .val_o   (db_val)
  );

  qdb_sq_bank #(.NUM_Q(NUM_Q), .PTR_W(PTR_W)) u_sq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_valid_i (cfg_valid_i),
    .cfg_op_i    (cfg_op),
    .cfg_qid_i   (cfg_qid_i),
    .cfg_size_i  (cfg_size_i),
    .cfg_cqid_i  (cfg_cqid_i),
    .tl_wr_i     (sq_wr),
    .tl_qid_i    (db_qid),
    .tl_val_i    (db_val),
    .tl_acc_o    (tl_acc),
    .pop_valid_i (pop_valid_i),
    .pop_sqid_i  (pop_sqid_i),
    .pop_ok_o    (pop_ok_o),
    .pop_slot_o  (pop_slot_o),
    .hd_sel_i    (post_sqid_i),
    .hd_o        (post_sq_head_o),
    .vld_o       (sq_vld),
    .cq_o        (sq_cq)
  );

  qdb_cq_bank #(.NUM_Q(NUM_Q), .PTR_W(PTR_W), .ST_W(ST_W)) u_cq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_valid_i   (cfg_valid_i),
    .cfg_op_i      (cfg_op),
    .cfg_qid_i     (cfg_qid_i),
    .cfg_size_i    (cfg_size_i),
    .cfg_ien_i     (cfg_ien_i),
    .hd_wr_i       (cq_wr),
    .hd_qid_i      (db_qid),
    .hd_val_i      (db_val),
    .wake_o        (wake),
    .post_valid_i  (post_valid_i),
    .post_cqid_i   (post_cqid_i),
    .post_status_i (post_status_i),
    .post_ok_o     (post_ok_o),
    .post_busy_o   (post_busy_o),
    .post_word_o   (post_word_o),
    .post_slot_o   (post_slot_o),
    .retry_o       (retry_req_o),
    .irq_o         (irq_o)
  );

  // SQs bound to the CQ whose full condition was just relieved
  for (genvar g = 0; g < NUM_Q; g++) begin : g_bind
    assign bound[g] = sq_vld[g] && (sq_cq[g] == db_qid);
  end

  assign fetch_d = (tl_acc ? (NUM_Q'(1) << db_qid) : '0) | (wake ? bound : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fetch_q <= '0;
    else         fetch_q <= fetch_d;
  end

  assign fetch_req_o = fetch_q;
endmodule

// File: rtl/qdb_tracker_chk.sv
module qdb_tracker_chk #(
  parameter int unsigned NUM_Q = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             db_valid_i,
  input logic             post_valid_i,
  input logic             post_ok_o,
  input logic             post_busy_o,
  input logic             pop_valid_i,
  input logic             pop_ok_o,
  input logic [NUM_Q-1:0] fetch_req_o,
  input logic [NUM_Q-1:0] retry_req_o,
  input logic [NUM_Q-1:0] irq_o
);
  assert_post_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_ok_o |-> !post_busy_o);
  assert_busy_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_busy_o |-> post_valid_i);
  assert_ok_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_ok_o |-> post_valid_i);
  assert_pop_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_ok_o |-> pop_valid_i);
  assert_irq_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  assert_irq_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> $past(db_valid_i));
  assert_retry_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(retry_req_o));
  assert_retry_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|retry_req_o) |-> $past(db_valid_i));
  assert_fetch_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fetch_req_o) |-> $past(db_valid_i));
endmodule

bind qdb_tracker qdb_tracker_chk #(.NUM_Q(NUM_Q)) u_chk (.*);

// File: tb/qdb_tracker_tb.sv
`timescale 1ns/1ps
module qdb_tracker_tb;
  localparam int NQ = 4;
  localparam int PW = 3;
  localparam int SW = 15;
  localparam int QW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cfg_valid = 0;
  logic [1:0]    cfg_op = 0;
  logic [QW-1:0] cfg_qid = 0;
  logic [PW-1:0] cfg_size = 0;
  logic [QW-1:0] cfg_cqid = 0;
  logic          cfg_ien = 0;
  logic          db_valid = 0;
  logic [15:0]   db_addr = 0;
  logic [31:0]   db_data = 0;
  logic          post_valid = 0;
  logic [QW-1:0] post_cqid = 0;
  logic [QW-1:0] post_sqid = 0;
  logic [SW-1:0] post_status = 0;
  logic          post_ok, post_busy;
  logic [SW:0]   post_word;
  logic [PW-1:0] post_slot, post_sq_head;
  logic          pop_valid = 0;
  logic [QW-1:0] pop_sqid = 0;
  logic          pop_ok;
  logic [PW-1:0] pop_slot;
  logic [NQ-1:0] fetch_req, retry_req, irq;

  qdb_tracker #(.NUM_Q(NQ), .PTR_W(PW), .ST_W(SW), .ADDR_W(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_valid_i(cfg_valid), .cfg_op_i(cfg_op), .cfg_qid_i(cfg_qid),
    .cfg_size_i(cfg_size), .cfg_cqid_i(cfg_cqid), .cfg_ien_i(cfg_ien),
    .db_valid_i(db_valid), .db_addr_i(db_addr), .db_data_i(db_data),
    .post_valid_i(post_valid), .post_cqid_i(post_cqid), .post_sqid_i(post_sqid),
    .post_status_i(post_status), .post_ok_o(post_ok), .post_busy_o(post_busy),
    .post_word_o(post_word), .post_slot_o(post_slot), .post_sq_head_o(post_sq_head),
    .pop_valid_i(pop_valid), .pop_sqid_i(pop_sqid), .pop_ok_o(pop_ok), .pop_slot_o(pop_slot),
    .fetch_req_o(fetch_req), .retry_req_o(retry_req), .irq_o(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference model
  int m_sq_v[NQ], m_sq_sz[NQ], m_sq_hd[NQ], m_sq_tl[NQ], m_sq_cq[NQ];
  int m_cq_v[NQ], m_cq_sz[NQ], m_cq_hd[NQ], m_cq_tl[NQ], m_cq_ph[NQ], m_cq_ien[NQ];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit cq_full(input int q);
    return m_cq_v[q] != 0 && ((m_cq_tl[q] + 1) % m_cq_sz[q]) == m_cq_hd[q];
  endfunction

  task automatic cfg(input int op, input int q, input int field, input int cq, input int ien);
    @(negedge clk);
    cfg_valid = 1; cfg_op = 2'(op); cfg_qid = QW'(q);
    cfg_size = PW'(field); cfg_cqid = QW'(cq); cfg_ien = ien[0];
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 0;
    case (op)
      0: begin m_sq_v[q] = 1; m_sq_sz[q] = field + 1; m_sq_hd[q] = 0; m_sq_tl[q] = 0; m_sq_cq[q] = cq; end
      1: begin m_cq_v[q] = 1; m_cq_sz[q] = field + 1; m_cq_hd[q] = 0; m_cq_tl[q] = 0;
               m_cq_ph[q] = 1; m_cq_ien[q] = ien; end
      2: m_sq_v[q] = 0;
      default: m_cq_v[q] = 0;
    endcase
  endtask

  task automatic db_wr(input int addr, input logic [31:0] data, input string tag);
    logic [NQ-1:0] ef, er, ei;
    int val, off, q;
    bit full;
    ef = '0; er = '0; ei = '0;
    val = int'(data[15:0]);
    if (addr >= 'h1000 && (addr & 3) == 0) begin
      off = addr - 'h1000;
      q = off >> 3;
      if (q < NQ) begin
        if (((off >> 2) & 1) == 0) begin
          if (m_sq_v[q] != 0 && val < m_sq_sz[q]) begin m_sq_tl[q] = val; ef[q] = 1'b1; end
        end else if (m_cq_v[q] != 0 && val < m_cq_sz[q]) begin
          full = cq_full(q);
          m_cq_hd[q] = val;
          if (full) begin
            er[q] = 1'b1;
            for (int s = 0; s < NQ; s++) if (m_sq_v[s] != 0 && m_sq_cq[s] == q) ef[s] = 1'b1;
          end
          if (m_cq_tl[q] != val && m_cq_ien[q] != 0) ei[q] = 1'b1;
        end
      end
    end
    @(negedge clk);
    db_valid = 1; db_addr = 16'(addr); db_data = data;
    @(posedge clk);
    @(negedge clk);
    db_valid = 0;
    #1;
    chk(tag, 32'(fetch_req), 32'(ef));
    chk("R4", 32'(irq), 32'(ei));
    chk("R5", 32'(retry_req), 32'(er));
  endtask

  task automatic post(input int cq, input int sq, input int st, input string tag);
    bit ok;
    ok = m_cq_v[cq] != 0 && !cq_full(cq);
    @(negedge clk);
    post_valid = 1; post_cqid = QW'(cq); post_sqid = QW'(sq); post_status = SW'(st);
    #1;
    chk("R6", 32'(post_ok), 32'(ok));
    chk("R7", 32'(post_busy), 32'(!ok));
    if (ok) begin
      chk(tag, 32'(post_word), 32'((st << 1) | m_cq_ph[cq]));
      chk(tag, 32'(post_slot), 32'(m_cq_tl[cq]));
      chk("R6", 32'(post_sq_head), 32'(m_sq_hd[sq]));
      m_cq_tl[cq] = (m_cq_tl[cq] + 1) % m_cq_sz[cq];
      if (m_cq_tl[cq] == 0) m_cq_ph[cq] ^= 1;
    end
    @(posedge clk);
    @(negedge clk);
    post_valid = 0;
  endtask

  task automatic pop(input int sq);
    bit ok;
    ok = m_sq_v[sq] != 0 && m_sq_hd[sq] != m_sq_tl[sq];
    @(negedge clk);
    pop_valid = 1; pop_sqid = QW'(sq);
    #1;
    chk("R9", 32'(pop_ok), 32'(ok));
    if (ok) begin
      chk("R9", 32'(pop_slot), 32'(m_sq_hd[sq]));
      m_sq_hd[sq] = (m_sq_hd[sq] + 1) % m_sq_sz[sq];
    end
    @(posedge clk);
    @(negedge clk);
    pop_valid = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin
      m_sq_v[q] = 0; m_sq_sz[q] = 0; m_sq_hd[q] = 0; m_sq_tl[q] = 0; m_sq_cq[q] = 0;
      m_cq_v[q] = 0; m_cq_sz[q] = 0; m_cq_hd[q] = 0; m_cq_tl[q] = 0; m_cq_ph[q] = 1; m_cq_ien[q] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11", 32'(fetch_req), 0);
    chk("R11", 32'(retry_req), 0);
    chk("R11", 32'(irq), 0);
    post(0, 0, 5, "R11");
    pop(0);
    db_wr('h1000, 32'd1, "R11");

    // R10 creation: CQ sizes 8,4,2,1
    cfg(1, 0, 7, 0, 1);
    cfg(1, 1, 3, 0, 1);
    cfg(1, 2, 1, 0, 0);
    cfg(1, 3, 0, 0, 1);
    cfg(0, 0, 7, 0, 0);
    cfg(0, 1, 3, 0, 0);
    cfg(0, 2, 5, 1, 0);
    cfg(0, 3, 0, 2, 0);

    // R1 address sweep across and beyond the window
    for (int a = 'h0FF8; a < 'h1028; a++)
      db_wr(a, 32'hA5A5_0000 | 32'((a * 5) & 15), "R1");

    // R3 boundary values, R12 upper data bits
    db_wr('h1008, 32'd4, "R3");
    db_wr('h1008, 32'd3, "R2");
    db_wr('h100C, 32'd4, "R3");
    db_wr('h1000, 32'h0003_0002, "R12");
    db_wr('h1000, 32'h0001_0009, "R12");

    // R8 post sweep on CQ0 with head updates and pops
    db_wr('h1004, 32'(m_cq_tl[0]), "R4");
    for (int i = 0; i < 60; i++) begin
      if (cq_full(0)) db_wr('h1004, 32'(m_cq_tl[0]), "R5");
      else if (i % 4 == 3 && m_cq_hd[0] != m_cq_tl[0])
        db_wr('h1004, 32'((m_cq_hd[0] + 1) % 8), "R4");
      else post(0, i % 2, (i * 37) & 32767, "R8");
      if (i % 5 == 0) begin
        db_wr('h1000, 32'((m_sq_tl[0] + 3) % 8), "R2");
        pop(0);
      end
    end

    // R7 and R5 on CQ1 (size 4)
    db_wr('h100C, 32'(m_cq_tl[1]), "R4");
    for (int i = 0; i < 5; i++) post(1, 2, 100 + i, "R6");
    post(1, 2, 200, "R7");
    db_wr('h100C, 32'(m_cq_tl[1]), "R5");
    post(1, 2, 201, "R7");

    // size-1 CQ is always full
    post(3, 0, 9, "R7");
    db_wr('h101C, 32'd0, "R5");

    // R9 pop sweep
    for (int s = 0; s < NQ; s++)
      for (int j = 0; j < 12; j++) begin
        if (j % 3 == 0) db_wr('h1000 + s * 8, 32'((m_sq_tl[s] + 2) % m_sq_sz[s]), "R2");
        else pop(s);
      end

    // R10 removal and re-creation
    cfg(2, 3, 0, 0, 0);
    db_wr('h1018, 32'd0, "R10");
    pop(3);
    cfg(3, 2, 0, 0, 0);
    post(2, 0, 3, "R10");
    db_wr('h1014, 32'd0, "R10");
    cfg(1, 2, 2, 0, 1);
    post(2, 0, 7, "R10");
    for (int i = 0; i < 12; i++) begin
      if (cq_full(2)) db_wr('h1014, 32'(m_cq_tl[2]), "R5");
      else post(2, 1, 300 + i, "R8");
    end

    finish_run();
  end
endmodule